// File: doc/BRIEF.md
# LED Matrix Row Scanner

This block refreshes one row of a multiplexed LED matrix with eight rows each time it is asked to. The column drive sits in an external chain of 8-bit shift registers. These are serial-in, parallel-out parts with an output latch. On a step request the scanner reads the two column bytes for its current row from a display buffer. It joins them into a 16-bit word and clocks the word into the chain one bit at a time. It then switches the row outputs off, strobes the chain's latch, and switches on the row that the new column pattern belongs to.

The order of these actions is fixed on purpose. The row bus is zero before the latch moves, and a row is driven again only after the latch has returned high. The previous row therefore never shows the next row's columns. Each half period of the shift clock lasts `PHASE_CYC` system clocks, which keeps the serial interface within the speed the external registers can take. After reset the block clears the external chain once and only then accepts requests. A row counter walks through the eight rows in order, one row per completed step.

Top module: `led_row_scanner`

## Requirements
- R1: After reset, `clear_n_o` is low while `latch_n_o` gives exactly one low pulse. `clear_n_o` then goes high. `busy_o` stays high until this sequence is over, and `row_o` stays 0x00 throughout it.
- R2: A `step_i` pulse while idle starts a scan step and raises `busy_o`. During the step the buffer is read at exactly two addresses, row*4 first and then row*4+1. Here row is the current row index, 0 to 7.
- R3: Each scan step produces exactly 16 rising edges on `ser_clk_o`, and no rising edge happens while the block is idle.
- R4: The word sent is {byte at row*4+1, byte at row*4}. It goes out most significant bit first. Each bit is on `ser_data_o` before its rising clock edge and does not change while `ser_clk_o` is high.
- R5: Every high phase of `ser_clk_o`, and every low phase between two bits of a step, lasts exactly `PHASE_CYC` system clocks.
- R6: After the last bit, `row_o` goes to 0x00 before `latch_n_o` falls. It stays 0x00 while `latch_n_o` is low. Each step gives exactly one latch low pulse.
- R7: After the latch has returned high, `row_o` takes the one-hot code 1 << row (row 0 = 0x01, row 7 = 0x80) of the row just shifted, and `busy_o` falls.
- R8: The row index starts at 0 after reset. It advances by one after each completed step and wraps from 7 back to 0.
- R9: A `step_i` pulse while `busy_o` is high is ignored. The step in progress still ends with 16 bits and one latch pulse, no second step follows, and the next accepted step uses the next row.
- R10: While idle, `row_o` holds its value, `ser_clk_o` stays low, `latch_n_o` stays high and no buffer read is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| step_i | input | 1 | Request one scan step (single-cycle strobe) |
| buf_rd_o | output | 1 | Display buffer read enable |
| buf_addr_o | output | ADDR_W | Display buffer byte address |
| buf_data_i | input | 8 | Buffer read data, valid the cycle after the read |
| ser_data_o | output | 1 | Serial column data to the register chain |
| ser_clk_o | output | 1 | Shift clock to the register chain |
| latch_n_o | output | 1 | Active-low output latch strobe of the chain |
| clear_n_o | output | 1 | Active-low clear of the chain |
| row_o | output | ROWS | One-hot row select, all zero when blanked |
| busy_o | output | 1 | High during reset clearing and during a scan step |

## Verification
The bench builds the scanner with `PHASE_CYC` = 3 and leaves the other parameters at their defaults: eight rows, 8-bit bytes, a 5-bit buffer address and four bytes per row. A phase of three clocks differs from one clock and from the two-cycle buffer fetch. A phase counter that is off by one therefore shows up as a wrong measured width. Ten table-driven steps cover the wrap from row 7 to row 0 and reload that row with new data. The table includes all-zero, all-one and alternating words, so a swapped byte order or a reversed bit order cannot go unnoticed.

// File: rtl/led_scan_pkg.sv
package led_scan_pkg;

  typedef enum logic [3:0] {
    S_INIT_CLR,
    S_INIT_LAT,
    S_INIT_REL,
    S_IDLE,
    S_RD0,
    S_RD1,
    S_CAP,
    S_CK_LO,
    S_CK_HI,
    S_BLANK,
    S_LAT_LO,
    S_LAT_HI
  } scan_state_e;

  // byte address of the first column byte of a row
  function automatic int unsigned row_base(int unsigned idx, int unsigned bytes_per_row);
    return idx * bytes_per_row;
  endfunction

  // one-hot select code for a row index
  function automatic logic [31:0] row_code(int unsigned idx);
    return 32'd1 << idx;
  endfunction

endpackage

// File: rtl/scan_phase_timer.sv
module scan_phase_timer #(
  parameter int PHASE_CYC = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  output logic tick
);
  localparam int CW = $clog2(PHASE_CYC + 1);

  logic [CW-1:0] cnt;

  assign tick = (cnt == CW'(PHASE_CYC - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt <= '0;
    else if (restart) cnt <= '0;
    else if (!tick)   cnt <= cnt + 1'b1;
  end

  assert_phase_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
    cnt < CW'(PHASE_CYC));

endmodule

// File: rtl/scan_word_shifter.sv
module scan_word_shifter #(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lo_cap,
  input  logic              hi_cap,
  input  logic              shift,
  input  logic [BYTE_W-1:0] data_i,
  output logic              msb_o,
  output logic              last_o
);
  localparam int WORD_BITS = 2 * BYTE_W;
  localparam int BW = $clog2(WORD_BITS);

  logic [BYTE_W-1:0]    lo_q;
  logic [WORD_BITS-1:0] word_q;
  logic [BW-1:0]        bit_q;

  assign msb_o  = word_q[WORD_BITS-1];
  assign last_o = (bit_q == BW'(WORD_BITS - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_q   <= '0;
      word_q <= '0;
      bit_q  <= '0;
    end else begin
      if (lo_cap) lo_q <= data_i;
      if (hi_cap) begin
        word_q <= {data_i, lo_q};
        bit_q  <= '0;
      end else if (shift) begin
        word_q <= {word_q[WORD_BITS-2:0], 1'b0};
        bit_q  <= bit_q + 1'b1;
      end
    end
  end

  // R3: a shift never runs past the final bit of the word
  assert_no_shift_past_last_R3: assert property (@(posedge clk) disable iff (!rst_n)
    shift |-> !last_o);

endmodule

// File: rtl/scan_row_driver.sv
module scan_row_driver #(
  parameter int ROWS = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    blank,
  input  logic                    show,
  output logic [$clog2(ROWS)-1:0] idx_o,
  output logic [ROWS-1:0]         row_o
);
  localparam int RW = $clog2(ROWS);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_o <= '0;
      row_o <= '0;
    end else if (blank) begin
      row_o <= '0;
    end else if (show) begin
      row_o <= ROWS'(led_scan_pkg::row_code(32'(idx_o)));
      idx_o <= idx_o + RW'(1);
    end
  end

  assert_row_onehot_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(row_o));

  assert_blank_then_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    blank |=> row_o == '0);

endmodule

// File: rtl/led_row_scanner.sv
module led_row_scanner #(
  parameter int PHASE_CYC = 4,
  parameter int ROWS      = 8,
  parameter int BYTE_W    = 8,
  parameter int ADDR_W    = 5,
  parameter int ROW_BYTES = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              step_i,
  output logic              buf_rd_o,
  output logic [ADDR_W-1:0] buf_addr_o,
  input  logic [BYTE_W-1:0] buf_data_i,
  output logic              ser_data_o,
  output logic              ser_clk_o,
  output logic              latch_n_o,
  output logic              clear_n_o,
  output logic [ROWS-1:0]   row_o,
  output logic              busy_o
);
  import led_scan_pkg::*;

  localparam int RW = $clog2(ROWS);

  scan_state_e state, state_nx;

  // named internal events
  logic          phase_tick;
  logic          state_chg;
  logic          bit_last;
  logic          bit_shift;
  logic          row_blank;
  logic          row_show;
  logic [RW-1:0] row_idx;

  always_comb begin
    state_nx = state;
    unique case (state)
      S_INIT_CLR: if (phase_tick) state_nx = S_INIT_LAT;
      S_INIT_LAT: if (phase_tick) state_nx = S_INIT_REL;
      S_INIT_REL: if (phase_tick) state_nx = S_IDLE;
      S_IDLE:     if (step_i)     state_nx = S_RD0;
      S_RD0:                      state_nx = S_RD1;
      S_RD1:                      state_nx = S_CAP;
      S_CAP:                      state_nx = S_CK_LO;
      S_CK_LO:    if (phase_tick) state_nx = S_CK_HI;
      S_CK_HI:    if (phase_tick) state_nx = bit_last ? S_BLANK : S_CK_LO;
      S_BLANK:    if (phase_tick) state_nx = S_LAT_LO;
      S_LAT_LO:   if (phase_tick) state_nx = S_LAT_HI;
      S_LAT_HI:   if (phase_tick) state_nx = S_IDLE;
      default:                    state_nx = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= S_INIT_CLR;
    else        state <= state_nx;
  end

  assign state_chg = (state_nx != state);
  assign bit_shift = (state == S_CK_HI) && phase_tick && !bit_last;
  assign row_blank = (state == S_CK_HI) && phase_tick && bit_last;
  assign row_show  = (state == S_LAT_HI) && phase_tick;

  scan_phase_timer #(.PHASE_CYC(PHASE_CYC)) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .restart (state_chg),
    .tick    (phase_tick)
  );

  scan_word_shifter #(.BYTE_W(BYTE_W)) u_shifter (
    .clk    (clk),
    .rst_n  (rst_n),
    .lo_cap (state == S_RD1),
    .hi_cap (state == S_CAP),
    .shift  (bit_shift),
    .data_i (buf_data_i),
    .msb_o  (ser_data_o),
    .last_o (bit_last)
  );

  scan_row_driver #(.ROWS(ROWS)) u_rows (
    .clk   (clk),
    .rst_n (rst_n),
    .blank (row_blank),
    .show  (row_show),
    .idx_o (row_idx),
    .row_o (row_o)
  );

  assign buf_rd_o   = (state == S_RD0) || (state == S_RD1);
  assign buf_addr_o = ADDR_W'(row_base(32'(row_idx), ROW_BYTES))
                    + ADDR_W'(state == S_RD1);
  assign ser_clk_o  = (state == S_CK_HI);
  assign latch_n_o  = !((state == S_INIT_LAT) || (state == S_LAT_LO));
  assign clear_n_o  = !((state == S_INIT_CLR) || (state == S_INIT_LAT)
                        || (state == S_INIT_REL));
  assign busy_o     = (state != S_IDLE);

  assert_clear_only_busy_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !clear_n_o |-> busy_o);

  assert_sclk_only_busy_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ser_clk_o) |-> busy_o);

  assert_data_stable_high_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (ser_clk_o && $past(ser_clk_o)) |-> $stable(ser_data_o));

  assert_row_dark_in_latch_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !latch_n_o |-> row_o == '0);

  assert_row_on_after_latch_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ((row_o != $past(row_o)) && (row_o != '0)) |-> (latch_n_o && $past(latch_n_o)));

  assert_row_hold_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && $past(!busy_o)) |-> $stable(row_o));

endmodule

// File: tb/led_row_scanner_bench.sv
module led_row_scanner_bench;
  localparam int P = 3;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       step_i = 1'b0;
  logic       buf_rd_o;
  logic [4:0] buf_addr_o;
  logic [7:0] rdata = 8'h00;
  logic       ser_data_o, ser_clk_o, latch_n_o, clear_n_o, busy_o;
  logic [7:0] row_o;

  always #2.5 clk = ~clk;

  led_row_scanner #(.PHASE_CYC(P)) u_led_row_scanner (
    .clk(clk), .rst_n(rst_n), .step_i(step_i),
    .buf_rd_o(buf_rd_o), .buf_addr_o(buf_addr_o), .buf_data_i(rdata),
    .ser_data_o(ser_data_o), .ser_clk_o(ser_clk_o), .latch_n_o(latch_n_o),
    .clear_n_o(clear_n_o), .row_o(row_o), .busy_o(busy_o)
  );

  // display buffer model, one cycle read latency
  logic [7:0] mem [32];
  always @(posedge clk) if (buf_rd_o) rdata <= mem[buf_addr_o];

  int tests = 0, fails = 0;
  bit done = 0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // port monitor, sampled at falling clock edges
  int nclk, nlat, init_lat, blank_err, width_err, stab_err, naddr, hi_run, lo_run;
  logic [15:0] cap;
  logic [4:0]  addr_log [4];
  logic prev_sclk = 0, prev_lat = 1, data_at_rise = 0;

  task automatic clear_mon();
    nclk = 0; nlat = 0; blank_err = 0; width_err = 0; stab_err = 0; naddr = 0;
    cap = '0;
    for (int k = 0; k < 4; k++) addr_log[k] = '0;
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      if (buf_rd_o) begin
        if (naddr < 4) addr_log[naddr] = buf_addr_o;
        naddr++;
      end
      if (ser_clk_o && !prev_sclk) begin
        cap = {cap[14:0], ser_data_o};
        nclk++;
        data_at_rise = ser_data_o;
        if (nclk > 1 && lo_run != P) width_err++;
        hi_run = 1;
      end else if (ser_clk_o) begin
        hi_run++;
        if (ser_data_o != data_at_rise) stab_err++;
      end
      if (!ser_clk_o && prev_sclk) begin
        if (hi_run != P) width_err++;
        lo_run = 1;
      end else if (!ser_clk_o) lo_run++;
      if (!latch_n_o) begin
        if (row_o != 8'h00) blank_err++;
        if (prev_lat) begin
          nlat++;
          if (!clear_n_o) init_lat++;
        end
      end
      prev_sclk = ser_clk_o;
      prev_lat  = latch_n_o;
    end
  end

  localparam logic [15:0] VEC [10] = '{
    16'h8001, 16'h0000, 16'hFFFF, 16'hA55A, 16'h1234,
    16'h00FF, 16'hFF00, 16'h7FFE, 16'hC3C3, 16'h0F0F};

  task automatic load_row(input int r, input logic [15:0] w);
    mem[r*4]   = w[7:0];
    mem[r*4+1] = w[15:8];
    mem[r*4+2] = 8'hA5;
    mem[r*4+3] = 8'h5A;
  endtask

  task automatic pulse_step();
    @(negedge clk); step_i = 1'b1;
    @(negedge clk); step_i = 1'b0;
  endtask

  task automatic wait_idle();
    while (busy_o) @(negedge clk);
  endtask

  task automatic run_step(input int r, input logic [15:0] w, input bit inject);
    load_row(r, w);
    clear_mon();
    pulse_step();
    check(busy_o == 1'b1, "R2 busy after step", int'(busy_o), 1);
    if (inject) begin
      repeat (20) @(negedge clk);
      step_i = 1'b1; @(negedge clk); step_i = 1'b0;
    end
    wait_idle();
    check(naddr == 2, "R2 read count", naddr, 2);
    check(addr_log[0] == 5'(r*4), "R2 first address", int'(addr_log[0]), r*4);
    check(addr_log[1] == 5'(r*4+1), "R2 second address", int'(addr_log[1]), r*4+1);
    check(nclk == 16, "R3 shift clock count", nclk, 16);
    check(cap == w, "R4 word order", int'(cap), int'(w));
    check(stab_err == 0, "R4 data stable while clock high", stab_err, 0);
    check(width_err == 0, "R5 phase width", width_err, 0);
    check(nlat == 1 && blank_err == 0, "R6 latch pulse with rows dark",
          nlat * 16 + blank_err, 16);
    check(row_o == 8'(1 << r), "R7 R8 row code", int'(row_o), 1 << r);
  endtask

  initial begin
    for (int k = 0; k < 32; k++) mem[k] = 8'h00;
    clear_mon();
    init_lat = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(clear_n_o == 1'b0 && busy_o == 1'b1, "R1 clearing after reset",
          {30'd0, clear_n_o, busy_o}, 1);
    check(row_o == 8'h00, "R1 rows dark at reset", int'(row_o), 0);
    wait_idle();
    check(init_lat == 1, "R1 one latch pulse under clear", init_lat, 1);
    check(clear_n_o == 1'b1 && latch_n_o == 1'b1, "R1 clear released",
          {30'd0, clear_n_o, latch_n_o}, 3);
    check(row_o == 8'h00, "R1 rows dark after init", int'(row_o), 0);

    for (int i = 0; i < 10; i++) begin
      run_step(i % 8, VEC[i], i == 4);
      if (i == 4) begin
        clear_mon();
        repeat (20) @(negedge clk);
        check(busy_o == 1'b0 && nclk == 0, "R9 step while busy ignored",
              nclk, 0);
      end
    end

    // R10: idle hold
    clear_mon();
    begin
      logic [7:0] held;
      logic bad;
      held = row_o;
      bad = 1'b0;
      repeat (40) begin
        @(negedge clk);
        if (row_o != held || ser_clk_o || !latch_n_o) bad = 1'b1;
      end
      check(!bad && naddr == 0 && nclk == 0, "R10 idle outputs hold",
            int'(bad) + naddr, 0);
    end

    // reset in the middle of a step restarts clearing and the row count
    load_row(0, 16'h3C96);
    pulse_step();
    repeat (15) @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    check(row_o == 8'h00 && clear_n_o == 1'b0, "R1 reset mid step",
          int'(row_o), 0);
    rst_n = 1'b1;
    init_lat = 0;
    @(negedge clk);
    wait_idle();
    check(init_lat == 1, "R1 clear pulse after second reset", init_lat, 1);
    run_step(0, 16'h3C96, 1'b0);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      tests++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

endmodule